// File: doc/BRIEF.md
# Register Bank Error Exception Sequencer

This block keeps count of how many register bank areas currently hold a saved context. Accepted interrupts that use a bank raise the count. Bank restore instructions lower it. The block flags two error cases. Overflow is an accepted bank-using interrupt that arrives while every area is occupied and overflow exceptions are enabled. Underflow is a restore that executes while no area is occupied.

On either error the block runs the exception entry on its own, using a single-word memory port with a valid/ready handshake:

1. It reads the handler address from the vector table.
2. It pushes the current status word onto a descending stack.
3. It pushes the return address onto the same stack.
4. It issues a one-cycle redirect to the fetch unit. This pulse carries the handler address, the updated stack pointer and the updated status word.

The saved return address depends on the error type. An overflow saves the address of the next instruction. An underflow saves the address of the restore instruction itself. For an overflow, the interrupt mask field of the updated status word is loaded with the level of the offending interrupt, so that nested interrupts are blocked.

The core wires `busy` back into its event logic. Any interrupt or restore event presented while `busy` is high is dropped by this block.

Top module: `rbank_err_seq`

## Requirements
- R1: After a synchronous reset the outputs are `bank_level` = 0 and `busy`, `mem_valid` and `redirect_valid` all low.
- R2: When idle, an accepted interrupt with `irq_uses_bank` = 1 raises `bank_level` by one if it is below NUM_BANKS (15). An accepted interrupt with `irq_uses_bank` = 0 leaves `bank_level` unchanged.
- R3: When idle, a restore strobe lowers `bank_level` by one if it is above zero. A restore presented in the same cycle as `irq_accept` is dropped and has no effect.
- R4: An overflow starts only when `bank_level` = NUM_BANKS, `ovf_enable` = 1, and a bank-using interrupt is accepted. With `ovf_enable` = 0 that interrupt starts no sequence and the count stays at NUM_BANKS.
- R5: An underflow starts when a restore strobe, not dropped under R3, arrives while `bank_level` = 0. The count stays 0.
- R6: The first memory access of a sequence is a read (`mem_write` = 0) at VEC_BASE + 4 × vector number. The overflow vector is OVF_VEC (9) and the underflow vector is UDF_VEC (10). With VEC_BASE = 0x100 these give addresses 0x124 and 0x128.
- R7: The second access writes the `sr_cur` value, captured at detection, to `sp_cur` − 4. The third access writes the saved PC to `sp_cur` − 8. At the redirect, `new_sp` equals `sp_cur` − 8. `sp_cur` is assumed word aligned.
- R8: The saved PC is `next_pc` for an overflow and `restore_pc` for an underflow, each sampled in the detection cycle.
- R9: At the redirect, `new_sr` equals the captured status word. For an overflow, bits [7:4] are replaced by `irq_level`. For an underflow, no bits are changed.
- R10: While `mem_valid` = 1 and `mem_ready` = 0, the values of `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold into the next cycle.
- R11: `redirect_valid` pulses for exactly one cycle, in the cycle after the third access completes, and carries `redirect_pc` = the word read from the vector table. `busy` is low in the following cycle.
- R12: `busy` is high from the cycle after detection through the redirect cycle. Interrupt and restore events presented while `busy` is high leave `bank_level` unchanged and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_accept | input | 1 | Interrupt accepted by the core this cycle |
| irq_level | input | 4 | Priority level of the accepted interrupt |
| irq_uses_bank | input | 1 | Accepted interrupt saves into a bank area |
| restore_strobe | input | 1 | Bank restore instruction executes this cycle |
| restore_pc | input | 32 | Address of the restore instruction |
| next_pc | input | 32 | Address of the next instruction to execute |
| ovf_enable | input | 1 | Enables overflow exceptions |
| sr_cur | input | 32 | Current status word |
| sp_cur | input | 32 | Current stack pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| busy | output | 1 | Exception sequence in progress |
| bank_level | output | 4 | Number of occupied bank areas |
| redirect_valid | output | 1 | One-cycle redirect to the handler |
| redirect_pc | output | 32 | Handler start address |
| new_sr | output | 32 | Status word to load at the redirect |
| new_sp | output | 32 | Stack pointer to load at the redirect |

## Verification
The hardest state to reach from the ports is overflow. It needs exactly fifteen unmatched bank-using interrupts, then a further one with the enable set. A random walk that treats raises and restores evenly seldom reaches that state.

The bench therefore uses two kinds of stimulus:
- A directed fill to the limit, first with the enable cleared and then set.
- Random phases that alternate between interrupt-heavy and restore-heavy stretches. These drive the count repeatedly against both ends.

Events keep arriving during sequences under randomly stalling memory, so that dropped events and held requests are also exercised.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_JUMP
  } seq_state_t;

  typedef enum logic {
    ERR_OVF,
    ERR_UDF
  } err_kind_t;

endpackage

// File: rtl/rbank_fill_ctr.sv
module rbank_fill_ctr #(
  parameter int NUM_BANKS = 15,
  parameter int CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             irq_accept,
  input  logic             irq_uses_bank,
  input  logic             restore_strobe,
  input  logic             ovf_enable,
  output logic [CNT_W-1:0] level,
  output logic             ovf_hit,
  output logic             udf_hit
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_BANKS);

  logic full, empty, bank_irq, restore_ev;

  assign full       = (level == LIMIT);
  assign empty      = (level == '0);
  // An interrupt acceptance wins over a restore in the same cycle.
  assign bank_irq   = irq_accept & irq_uses_bank & ~hold;
  assign restore_ev = restore_strobe & ~irq_accept & ~hold;

  assign ovf_hit = bank_irq & full & ovf_enable;
  assign udf_hit = restore_ev & empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (bank_irq && !full) begin
      level <= level + 1'b1;
    end else if (restore_ev && !empty) begin
      level <= level - 1'b1;
    end
  end

endmodule

// File: rtl/rbank_exc_fsm.sv
module rbank_exc_fsm
  import rbank_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter int              LVL_W    = 4,
  parameter int              MASK_LSB = 4,
  parameter logic [WORD_W-1:0] VEC_BASE = 32'h0000_0100,
  parameter int              OVF_VEC  = 9,
  parameter int              UDF_VEC  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ovf_hit,
  input  logic              udf_hit,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [WORD_W-1:0] next_pc,
  input  logic [WORD_W-1:0] restore_pc,
  input  logic [WORD_W-1:0] sr_cur,
  input  logic [WORD_W-1:0] sp_cur,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              redirect_valid,
  output logic [WORD_W-1:0] redirect_pc,
  output logic [WORD_W-1:0] new_sr,
  output logic [WORD_W-1:0] new_sp
);

  localparam logic [WORD_W-1:0] STEP     = WORD_W'(4);
  localparam logic [WORD_W-1:0] OVF_ADDR = VEC_BASE + (WORD_W'(OVF_VEC) << 2);
  localparam logic [WORD_W-1:0] UDF_ADDR = VEC_BASE + (WORD_W'(UDF_VEC) << 2);

  seq_state_t        state;
  logic [WORD_W-1:0] pc_q, sr_q, sp_q, handler_q;
  logic [WORD_W-1:0] sr_masked;

  assign busy = (state != ST_IDLE);

  always_comb begin
    sr_masked = sr_cur;
    sr_masked[MASK_LSB +: LVL_W] = irq_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      mem_valid      <= 1'b0;
      mem_write      <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      new_sr         <= '0;
      new_sp         <= '0;
      pc_q           <= '0;
      sr_q           <= '0;
      sp_q           <= '0;
      handler_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ovf_hit || udf_hit) begin
            state     <= ST_VEC;
            mem_valid <= 1'b1;
            mem_write <= 1'b0;
            mem_addr  <= ovf_hit ? OVF_ADDR : UDF_ADDR;
            pc_q      <= ovf_hit ? next_pc : restore_pc;
            new_sr    <= ovf_hit ? sr_masked : sr_cur;
            sr_q      <= sr_cur;
            sp_q      <= sp_cur;
          end
        end
        ST_VEC: begin
          if (mem_ready) begin
            state     <= ST_PUSH_SR;
            handler_q <= mem_rdata;
            mem_write <= 1'b1;
            mem_addr  <= sp_q - STEP;
            mem_wdata <= sr_q;
            sp_q      <= sp_q - STEP;
          end
        end
        ST_PUSH_SR: begin
          if (mem_ready) begin
            state     <= ST_PUSH_PC;
            mem_addr  <= sp_q - STEP;
            mem_wdata <= pc_q;
            sp_q      <= sp_q - STEP;
          end
        end
        ST_PUSH_PC: begin
          if (mem_ready) begin
            state          <= ST_JUMP;
            mem_valid      <= 1'b0;
            mem_write      <= 1'b0;
            redirect_valid <= 1'b1;
            redirect_pc    <= handler_q;
            new_sp         <= sp_q;
          end
        end
        ST_JUMP: begin
          state          <= ST_IDLE;
          redirect_valid <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rbank_err_seq.sv
module rbank_err_seq #(
  parameter int                NUM_BANKS = 15,
  parameter int                WORD_W    = 32,
  parameter int                LVL_W     = 4,
  parameter int                MASK_LSB  = 4,
  parameter logic [WORD_W-1:0] VEC_BASE  = 32'h0000_0100,
  parameter int                OVF_VEC   = 9,
  parameter int                UDF_VEC   = 10,
  parameter int                CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_accept,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              irq_uses_bank,
  input  logic              restore_strobe,
  input  logic [WORD_W-1:0] restore_pc,
  input  logic [WORD_W-1:0] next_pc,
  input  logic              ovf_enable,
  input  logic [WORD_W-1:0] sr_cur,
  input  logic [WORD_W-1:0] sp_cur,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic [CNT_W-1:0]  bank_level,
  output logic              redirect_valid,
  output logic [WORD_W-1:0] redirect_pc,
  output logic [WORD_W-1:0] new_sr,
  output logic [WORD_W-1:0] new_sp
);

  logic ovf_hit, udf_hit;

  rbank_fill_ctr #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W)
  ) u_fill (
    .clk            (clk),
    .rst            (rst),
    .hold           (busy),
    .irq_accept     (irq_accept),
    .irq_uses_bank  (irq_uses_bank),
    .restore_strobe (restore_strobe),
    .ovf_enable     (ovf_enable),
    .level          (bank_level),
    .ovf_hit        (ovf_hit),
    .udf_hit        (udf_hit)
  );

  rbank_exc_fsm #(
    .WORD_W   (WORD_W),
    .LVL_W    (LVL_W),
    .MASK_LSB (MASK_LSB),
    .VEC_BASE (VEC_BASE),
    .OVF_VEC  (OVF_VEC),
    .UDF_VEC  (UDF_VEC)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .ovf_hit        (ovf_hit),
    .udf_hit        (udf_hit),
    .irq_level      (irq_level),
    .next_pc        (next_pc),
    .restore_pc     (restore_pc),
    .sr_cur         (sr_cur),
    .sp_cur         (sp_cur),
    .mem_ready      (mem_ready),
    .mem_rdata      (mem_rdata),
    .busy           (busy),
    .mem_valid      (mem_valid),
    .mem_write      (mem_write),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .new_sr         (new_sr),
    .new_sp         (new_sp)
  );

endmodule

// File: rtl/rbank_err_seq_chk.sv
module rbank_err_seq_chk #(
  parameter int NUM_BANKS = 15,
  parameter int WORD_W    = 32,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_valid,
  input logic              mem_write,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              busy,
  input logic [CNT_W-1:0]  bank_level,
  input logic              redirect_valid
);

  // R2: the count never passes the number of areas
  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    bank_level <= CNT_W'(NUM_BANKS));

  // R3: the count moves by at most one per cycle
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bank_level == $past(bank_level)) ||
             (bank_level == $past(bank_level) + 1'b1) ||
             (bank_level == $past(bank_level) - 1'b1));

  // R10: a stalled request holds
  a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_wdata) && $stable(mem_write)));

  // R7: stack and vector addresses are word aligned
  a_r7_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R11: one-cycle redirect, then idle
  a_r11_redirect_pulse: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> (!redirect_valid && !busy));

  // R11: no memory traffic outside a sequence
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_valid && !redirect_valid));

  // R12: the count is frozen while busy
  a_r12_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(bank_level));

endmodule

bind rbank_err_seq rbank_err_seq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .WORD_W    (WORD_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mem_valid      (mem_valid),
  .mem_write      (mem_write),
  .mem_addr       (mem_addr),
  .mem_wdata      (mem_wdata),
  .mem_ready      (mem_ready),
  .busy           (busy),
  .bank_level     (bank_level),
  .redirect_valid (redirect_valid)
);

// File: tb/tb_rbank_err_seq.sv
module tb_rbank_err_seq;

  localparam int          NB    = 15;
  localparam logic [31:0] VBASE = 32'h0000_0100;
  localparam int          OVN   = 9;
  localparam int          UDN   = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_accept = 0, irq_uses_bank = 0, restore_strobe = 0, ovf_enable = 0;
  logic [3:0]  irq_level = 0;
  logic [31:0] restore_pc = 0, next_pc = 0, sr_cur = 0, sp_cur = 0;
  logic        mem_valid, mem_write, mem_ready = 0, busy, redirect_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, redirect_pc, new_sr, new_sp;
  logic [3:0]  bank_level;

  always #10 clk = ~clk;

  function automatic logic [31:0] vec_word(input logic [31:0] a);
    return {a[15:0], 16'hC0DE} ^ 32'h8000_0000;
  endfunction

  assign mem_rdata = vec_word(mem_addr);

  rbank_err_seq dut (
    .clk(clk), .rst(rst), .irq_accept(irq_accept), .irq_level(irq_level),
    .irq_uses_bank(irq_uses_bank), .restore_strobe(restore_strobe),
    .restore_pc(restore_pc), .next_pc(next_pc), .ovf_enable(ovf_enable),
    .sr_cur(sr_cur), .sp_cur(sp_cur), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .bank_level(bank_level),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .new_sr(new_sr), .new_sp(new_sp)
  );

  int n_chk = 0, n_fail = 0;
  int m_level = 0;
  bit in_seq = 0;
  bit e_ovf;
  logic [31:0] e_pc, e_sr, e_sp, e_newsr;
  int log_n;
  logic        l_wr [4];
  logic [31:0] l_addr [4], l_data [4];
  bit stalled = 0;
  logic [31:0] st_addr, st_data;
  logic        st_wr;
  int seen_ovf = 0, seen_udf = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fold_mask(input logic [31:0] s, input logic [3:0] l);
    logic [31:0] r;
    r = s;
    r[7:4] = l;
    return r;
  endfunction

  task automatic finish_seq_checks();
    logic [31:0] va;
    va = VBASE + 32'((e_ovf ? OVN : UDN) * 4);
    chk(in_seq, "R11 redirect only inside a sequence", {31'd0, in_seq}, 32'd1);
    chk(log_n == 3, "R11 redirect after three accesses", 32'(log_n), 32'd3);
    if (log_n == 3) begin
      chk(!l_wr[0] && l_addr[0] == va, "R6 vector read address", l_addr[0], va);
      chk(l_wr[1] && l_addr[1] == e_sp - 4, "R7 status push address", l_addr[1], e_sp - 4);
      chk(l_data[1] == e_sr, "R7 status push data", l_data[1], e_sr);
      chk(l_wr[2] && l_addr[2] == e_sp - 8, "R7 PC push address", l_addr[2], e_sp - 8);
      chk(l_data[2] == e_pc, "R8 saved PC", l_data[2], e_pc);
    end
    chk(redirect_pc == vec_word(va), "R11 handler address", redirect_pc, vec_word(va));
    chk(new_sp == e_sp - 8, "R7 new stack pointer", new_sp, e_sp - 8);
    chk(new_sr == e_newsr, "R9 new status word", new_sr, e_newsr);
  endtask

  // one clock: observe at the falling edge, then drive for the next rising edge
  task automatic tick(input bit ia, input logic [3:0] lv, input bit ub, input bit rs, input bit oe);
    bit done;
    @(negedge clk);
    chk(32'(bank_level) == m_level, "R2/R3/R12 bank_level", 32'(bank_level), 32'(m_level));
    chk(busy == in_seq, "R12 busy window", {31'd0, busy}, {31'd0, in_seq});
    done = redirect_valid;
    if (done) finish_seq_checks();
    irq_accept = ia; irq_level = lv; irq_uses_bank = ub;
    restore_strobe = rs; ovf_enable = oe;
    sr_cur = $urandom; sp_cur = {$urandom, 2'b00} | 32'h0001_0000;
    next_pc = {$urandom, 1'b0}; restore_pc = {$urandom, 1'b0};
    mem_ready = ($urandom % 3) != 0;
    if (!in_seq) begin
      if (ia && ub) begin
        if (m_level == NB) begin
          if (oe) begin
            in_seq = 1; e_ovf = 1; e_pc = next_pc; e_sr = sr_cur; e_sp = sp_cur;
            e_newsr = fold_mask(sr_cur, lv); log_n = 0; seen_ovf++;
          end
        end else m_level++;
      end else if (rs && !ia) begin
        if (m_level == 0) begin
          in_seq = 1; e_ovf = 0; e_pc = restore_pc; e_sr = sr_cur; e_sp = sp_cur;
          e_newsr = sr_cur; log_n = 0; seen_udf++;
        end else m_level--;
      end
    end
    #1;
    if (stalled)
      chk(mem_valid && mem_addr == st_addr && mem_wdata == st_data && mem_write == st_wr,
          "R10 stalled request held", mem_addr, st_addr);
    stalled = mem_valid && !mem_ready;
    st_addr = mem_addr; st_data = mem_wdata; st_wr = mem_write;
    if (mem_valid && mem_ready && log_n < 4) begin
      l_wr[log_n] = mem_write; l_addr[log_n] = mem_addr; l_data[log_n] = mem_wdata;
      log_n++;
    end
    if (done) in_seq = 0;
  endtask

  task automatic tick_rand(input int rs_pct, input int oe_pct);
    bit rs;
    bit ia;
    ia = ($urandom % 100) < (100 - rs_pct) / 2;
    rs = ($urandom % 100) < rs_pct;
    tick(ia, 4'($urandom), ($urandom % 5) != 0, rs, ($urandom % 100) < oe_pct);
  endtask

  task automatic drain();
    while (in_seq) tick_rand(50, 50);
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(bank_level == 0, "R1 reset level", 32'(bank_level), 0);
    chk(!busy && !mem_valid && !redirect_valid, "R1 reset idle",
        {29'd0, busy, mem_valid, redirect_valid}, 0);
    // R5 underflow from an empty state
    tick(0, 0, 0, 1, 0);
    drain();
    // R2 non-bank interrupts do not count
    repeat (3) tick(1, 4'd3, 0, 0, 1);
    // fill to the limit with overflow disabled
    repeat (NB) tick(1, 4'd2, 1, 0, 0);
    // R4 full but disabled: no sequence
    tick(1, 4'd5, 1, 0, 0);
    tick(0, 0, 0, 0, 0);
    chk(!busy, "R4 disabled overflow starts nothing", {31'd0, busy}, 0);
    // R3 restore dropped when an interrupt is accepted in the same cycle
    tick(1, 4'd1, 0, 1, 0);
    // R4 / R9 overflow with level 11
    tick(1, 4'd11, 1, 0, 1);
    drain();
    // R12 events during a sequence were random; now random phases
    for (int ph = 0; ph < 24; ph++) begin
      for (int k = 0; k < 180; k++) begin
        if (ph % 2 == 0) tick_rand(15, 70);
        else tick_rand(80, 70);
      end
    end
    drain();
    repeat (3) tick(0, 0, 0, 0, 0);
    chk(seen_ovf >= 2, "R4 overflow sequences seen", 32'(seen_ovf), 2);
    chk(seen_udf >= 2, "R5 underflow sequences seen", 32'(seen_udf), 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule